// File: doc/BRIEF.md
# Instruction Parcel Aligner

The aligner sits between a 32-bit instruction fetch port and an instruction decoder. Each fetched word is split into two 16-bit parcels. The parcel from the lower halfword address is `word_data_i[15:0]`, whatever the data endianness. The parcels go into a small parcel queue. Complete instructions are assembled from the head of that queue and presented on a valid/ready stream.

The length of an instruction is taken from the two low bits of its first parcel alone. The value 2'b11 marks a 32-bit instruction, and any other value marks a 16-bit one. A 32-bit instruction may therefore start in the upper half of one fetch word and finish in the lower half of the next.

A redirect empties the queue and loads a new halfword-aligned program counter. Words supplied after a redirect must start at the word that holds the new PC. When the new PC sits in the upper half of that word, the lower parcel of that word is dropped.

Top module: `ipa_aligner`

## Requirements
- R1: When the first parcel's bits [1:0] are not 2'b11, the output is a 16-bit instruction: `ins_short_o`=1, `ins_data_o[15:0]` equals that parcel and `ins_data_o[31:16]` is zero. It is emitted as soon as that single parcel is held, without waiting for a later parcel.
- R2: When the first parcel's bits [1:0] are 2'b11, the output is a 32-bit instruction: `ins_short_o`=0 and `ins_data_o` = {next parcel, first parcel}.
- R3: `ins_addr_o` is the byte address of the instruction's first parcel. It is even, and after each accepted instruction it advances by 2 (16-bit) or 4 (32-bit), so instructions leave in memory order with none lost or repeated.
- R4: A 32-bit instruction whose first parcel is the upper half of a fetch word is held, with `ins_valid_o` low, until the next word is accepted. It is then emitted whole with the address of its first parcel.
- R5: A redirect discards all held parcels and sets the next instruction address to `redirect_pc_i` with bit 0 cleared. `ins_valid_o` is low during the redirect cycle and a word offered in that cycle is not taken. If bit 1 of the new PC is set, the lower parcel of the first word accepted afterwards is dropped.
- R6: While `ins_valid_o` is high and `ins_ready_i` is low, the presented instruction, its flag and its address stay unchanged in the next cycle unless a redirect occurs.
- R7: `word_ready_o` is high only when the queue has room for two more parcels. With the default depth of 4 and no instruction leaving, exactly two words are accepted, and no held parcel is overwritten.
- R8: After reset `ins_valid_o` is low and `word_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| redirect_i | input | 1 | Flush and load a new PC |
| redirect_pc_i | input | AW | New PC, byte address |
| word_valid_i | input | 1 | Fetched word present |
| word_data_i | input | 32 | Fetched word, [15:0] is the lower-address parcel |
| word_ready_o | output | 1 | Aligner takes the word this cycle |
| ins_valid_o | output | 1 | Instruction present |
| ins_ready_i | input | 1 | Decoder takes the instruction |
| ins_data_o | output | 32 | Instruction bits, upper half zero for 16-bit |
| ins_short_o | output | 1 | 1 for a 16-bit instruction |
| ins_addr_o | output | AW | Byte address of the first parcel |

## Verification
The hardest state to reach is a 32-bit instruction straddling two words while the queue is close to full. The decoder is also stalling, and new words are arriving. The bench sweeps generated parcel streams of only short, only long and mixed lengths from several odd and even halfword start addresses. Stalls on both sides are interleaved so that straddles meet a full queue at different phases. Directed steps hold a split instruction with no next word and fill the queue with the decoder stalled.

// File: rtl/ipa_pkg.sv
`timescale 1ns/1ps
package ipa_pkg;
  localparam int PARCEL_W = 16;
  localparam int INSN_W   = 32;

  // a parcel opens a 32-bit instruction when its two low bits are both set
  function automatic logic opens_long(input logic [PARCEL_W-1:0] p);
    return p[1:0] == 2'b11;
  endfunction

  // number of parcels an instruction with this first parcel occupies
  function automatic logic [1:0] parcels_of(input logic [PARCEL_W-1:0] p);
    return opens_long(p) ? 2'd2 : 2'd1;
  endfunction

  // byte step of the program counter after an instruction
  function automatic logic [2:0] byte_step(input logic is_short);
    return is_short ? 3'd2 : 3'd4;
  endfunction
endpackage

// File: rtl/ipa_parcel_q.sv
`timescale 1ns/1ps
module ipa_parcel_q #(
  parameter int DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic [1:0]                    push_n,
  input  logic [ipa_pkg::PARCEL_W-1:0]  push_first,
  input  logic [ipa_pkg::PARCEL_W-1:0]  push_second,
  input  logic [1:0]                    pop_n,
  output logic [ipa_pkg::PARCEL_W-1:0]  head0,
  output logic [ipa_pkg::PARCEL_W-1:0]  head1,
  output logic [$clog2(DEPTH+1)-1:0]    count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [ipa_pkg::PARCEL_W-1:0] slot [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW-1:0] wr_nx, rd_nx;

  assign wr_nx = wr_ptr + PW'(1);
  assign rd_nx = rd_ptr + PW'(1);

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      localparam logic [PW-1:0] IDX = PW'(i);
      always_ff @(posedge clk) begin
        if (!flush && push_n != 2'd0 && wr_ptr == IDX)
          slot[i] <= push_first;
        else if (!flush && push_n == 2'd2 && wr_nx == IDX)
          slot[i] <= push_second;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(push_n);
      rd_ptr <= rd_ptr + PW'(pop_n);
      count  <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  assign head0 = slot[rd_ptr];
  assign head1 = slot[rd_nx];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= count); // R7
  AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push_n != 2'd0) |-> (count <= CW'(DEPTH-2))); // R7
endmodule

// File: rtl/ipa_len.sv
`timescale 1ns/1ps
module ipa_len #(
  parameter int CW = 3
) (
  input  logic [ipa_pkg::PARCEL_W-1:0] head0,
  input  logic [ipa_pkg::PARCEL_W-1:0] head1,
  input  logic [CW-1:0]                count,
  output logic                         avail,
  output logic                         is_short,
  output logic [1:0]                   need,
  output logic [ipa_pkg::INSN_W-1:0]   insn
);
  always_comb begin
    need     = ipa_pkg::parcels_of(head0);
    is_short = !ipa_pkg::opens_long(head0);
    avail    = count >= CW'(need);
    insn     = is_short ? {16'h0000, head0} : {head1, head0};
  end
endmodule

// File: rtl/ipa_aligner.sv
`timescale 1ns/1ps
module ipa_aligner #(
  parameter int AW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_pc_i,
  input  logic          word_valid_i,
  input  logic [31:0]   word_data_i,
  output logic          word_ready_o,
  output logic          ins_valid_o,
  input  logic          ins_ready_i,
  output logic [31:0]   ins_data_o,
  output logic          ins_short_o,
  output logic [AW-1:0] ins_addr_o
);
  localparam int CW = $clog2(DEPTH+1);

  logic [AW-1:0] pc_q;
  logic          skip_q;
  logic [CW-1:0] count;
  logic [15:0]   head0, head1;
  logic          avail, is_short;
  logic [1:0]    need, push_n, pop_n;
  logic [15:0]   push_first;
  logic          word_fire, ins_fire, has_room;

  assign has_room     = count <= CW'(DEPTH-2);
  assign word_ready_o = !redirect_i && has_room;
  assign word_fire    = word_valid_i && word_ready_o;
  assign push_n       = word_fire ? (skip_q ? 2'd1 : 2'd2) : 2'd0;
  assign push_first   = skip_q ? word_data_i[31:16] : word_data_i[15:0];

  assign ins_valid_o  = avail && !redirect_i;
  assign ins_fire     = ins_valid_o && ins_ready_i;
  assign pop_n        = ins_fire ? need : 2'd0;
  assign ins_short_o  = is_short;
  assign ins_addr_o   = pc_q;

  ipa_parcel_q #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .flush(redirect_i),
    .push_n(push_n), .push_first(push_first), .push_second(word_data_i[31:16]),
    .pop_n(pop_n), .head0(head0), .head1(head1), .count(count)
  );

  ipa_len #(.CW(CW)) u_len (
    .head0(head0), .head1(head1), .count(count),
    .avail(avail), .is_short(is_short), .need(need), .insn(ins_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      skip_q <= 1'b0;
    end else if (redirect_i) begin
      pc_q   <= {redirect_pc_i[AW-1:1], 1'b0};
      skip_q <= redirect_pc_i[1];
    end else begin
      if (ins_fire) pc_q <= pc_q + AW'(ipa_pkg::byte_step(is_short));
      if (word_fire) skip_q <= 1'b0;
    end
  end

  AST_SHORT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_o && ins_short_o) |-> (ins_data_o[31:16] == 16'h0 && ins_data_o[1:0] != 2'b11)); // R1
  AST_LONG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_o && !ins_short_o) |-> (ins_data_o[1:0] == 2'b11)); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && !redirect_i) |=> (ins_addr_o == $past(ins_addr_o) + ($past(ins_short_o) ? AW'(2) : AW'(4)))); // R3
  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid_o |-> !ins_addr_o[0]); // R3
  AST_REDIRECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> (count == '0 && ins_addr_o == {$past(redirect_pc_i[AW-1:1]), 1'b0})); // R5
  AST_REDIRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |-> (!ins_valid_o && !word_ready_o)); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_o && !ins_ready_i && !redirect_i) |=>
      (redirect_i || (ins_valid_o && $stable(ins_data_o) && $stable(ins_addr_o) && $stable(ins_short_o)))); // R6
endmodule

// File: tb/ipa_aligner_test.sv
`timescale 1ns/1ps
module ipa_aligner_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic redirect = 1'b0;
  logic [31:0] rpc = '0;
  logic wv = 1'b0;
  logic [31:0] wd = '0;
  logic word_ready;
  logic ins_valid;
  logic ins_ready = 1'b0;
  logic [31:0] ins_data;
  logic ins_short;
  logic [31:0] ins_addr;

  int checks = 0;
  int fails  = 0;

  logic [31:0] exp_data  [64];
  logic [31:0] exp_addr  [64];
  logic        exp_short [64];
  int nexp;

  always #5 clk = ~clk;

  ipa_aligner #(.AW(32), .DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .redirect_i(redirect), .redirect_pc_i(rpc),
    .word_valid_i(wv), .word_data_i(wd), .word_ready_o(word_ready),
    .ins_valid_o(ins_valid), .ins_ready_i(ins_ready), .ins_data_o(ins_data),
    .ins_short_o(ins_short), .ins_addr_o(ins_addr)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [15:0] parcel(input int mode, input int k);
    logic [15:0] p;
    p = 16'((k + 1) * 40503 + mode * 7919);
    if (mode == 0) p[1:0] = 2'(k % 3);
    else if (mode == 1) p[1:0] = 2'b11;
    return p;
  endfunction

  function automatic logic [31:0] word_at(input int mode, input int w);
    return {parcel(mode, 2*w + 1), parcel(mode, 2*w)};
  endfunction

  task automatic build_expect(input int mode, input int start);
    int h;
    h = start / 2;
    nexp = 0;
    while (h < 64) begin
      if (parcel(mode, h)[1:0] == 2'b11) begin
        if (h + 1 >= 64) break;
        exp_data[nexp]  = {parcel(mode, h + 1), parcel(mode, h)};
        exp_short[nexp] = 1'b0;
        exp_addr[nexp]  = 32'(h * 2);
        h += 2;
      end else begin
        exp_data[nexp]  = {16'h0, parcel(mode, h)};
        exp_short[nexp] = 1'b1;
        exp_addr[nexp]  = 32'(h * 2);
        h += 1;
      end
      nexp++;
    end
  endtask

  task automatic do_redirect(input logic [31:0] pc);
    @(negedge clk);
    redirect = 1'b1; rpc = pc; wv = 1'b1; ins_ready = 1'b1;
    #1;
    chk(!ins_valid && !word_ready, "R5 quiet during redirect", {62'h0, ins_valid, word_ready}, 64'h0);
    @(negedge clk);
    redirect = 1'b0; wv = 1'b0;
  endtask

  task automatic run_seq(input int mode, input int start, input int run);
    int widx, idx, guard;
    logic stall;
    logic [31:0] sd, sa;
    build_expect(mode, start);
    do_redirect(32'(start));
    widx = start / 4; idx = 0; guard = 0; stall = 1'b0; sd = '0; sa = '0;
    while ((idx < nexp || widx < 32) && guard < 3000) begin
      wv = (widx < 32) && (((guard * 3 + run) % 7) != 3);
      wd = word_at(mode, widx);
      ins_ready = (run == 0) ? 1'b1 : (((guard * 7 + run) % 5) != 0);
      #1;
      if (stall)
        chk(ins_valid && ins_data == sd && ins_addr == sa, "R6 held while stalled",
            {ins_addr, ins_data}, {sa, sd});
      if (wv && word_ready) widx++;
      if (ins_valid) begin
        if (idx < nexp) begin
          chk(ins_data == exp_data[idx] && ins_short == exp_short[idx],
              exp_short[idx] ? "R1 short insn" : "R2 long insn",
              {31'h0, ins_short, ins_data}, {31'h0, exp_short[idx], exp_data[idx]});
          chk(ins_addr == exp_addr[idx], "R3 address order", 64'(ins_addr), 64'(exp_addr[idx]));
        end else begin
          chk(1'b0, "R3 extra insn", 64'(ins_addr), 64'hFFFF_FFFF);
        end
        if (ins_ready) idx++;
      end
      stall = ins_valid && !ins_ready;
      sd = ins_data; sa = ins_addr;
      @(negedge clk);
      guard++;
    end
    chk(guard < 3000, "R3 run completes", 64'(idx), 64'(nexp));
    wv = 1'b0; ins_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(!ins_valid, "R3 nothing after last insn", 64'(ins_valid), 64'h0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int acc;
    repeat (3) @(negedge clk);
    #1;
    chk(!ins_valid, "R8 reset valid low", 64'(ins_valid), 64'h0);
    chk(word_ready, "R8 reset ready high", 64'(word_ready), 64'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: a long instruction split across words is held until the second word
    do_redirect(32'h0);
    wv = 1'b1; wd = {16'hAAA3, 16'h0001}; ins_ready = 1'b1;
    #1;
    @(negedge clk);
    wv = 1'b0;
    #1;
    chk(ins_valid && ins_short && ins_data == 32'h0000_0001 && ins_addr == 32'h0,
        "R1 short emitted alone", {ins_addr, ins_data}, {32'h0, 32'h1});
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      #1;
      chk(!ins_valid, "R4 split insn held", 64'(ins_valid), 64'h0);
      @(negedge clk);
    end
    wv = 1'b1; wd = {16'h0000, 16'h1234};
    #1;
    @(negedge clk);
    wv = 1'b0;
    #1;
    chk(ins_valid && !ins_short && ins_data == 32'h1234_AAA3 && ins_addr == 32'h2,
        "R4 split insn joined", {ins_addr, ins_data}, {32'h2, 32'h1234_AAA3});
    @(negedge clk);
    #1;
    chk(ins_valid && ins_short && ins_data == 32'h0 && ins_addr == 32'h6,
        "R1 trailing short", {ins_addr, ins_data}, {32'h6, 32'h0});

    // R5: odd-halfword redirect drops the lower parcel
    do_redirect(32'h0000_0106);
    wv = 1'b1; wd = {16'h5552, 16'h7777}; ins_ready = 1'b1;
    #1;
    @(negedge clk);
    wv = 1'b0;
    #1;
    chk(ins_valid && ins_short && ins_data == 32'h5552 && ins_addr == 32'h106,
        "R5 lower parcel dropped", {ins_addr, ins_data}, {32'h106, 32'h5552});
    @(negedge clk);
    #1;
    chk(!ins_valid, "R5 only upper parcel kept", 64'(ins_valid), 64'h0);

    // R7: no drain, queue of four parcels takes two words
    do_redirect(32'h0);
    ins_ready = 1'b0; acc = 0;
    for (int i = 0; i < 8; i++) begin
      wv = 1'b1; wd = {16'h2003 + 16'(i * 16), 16'h1003 + 16'(i * 16)};
      #1;
      if (word_ready) acc++;
      @(negedge clk);
    end
    #1;
    chk(acc == 2, "R7 words accepted when full", 64'(acc), 64'h2);
    chk(!word_ready, "R7 ready low when full", 64'(word_ready), 64'h0);
    wv = 1'b0; ins_ready = 1'b1;
    chk(ins_valid && ins_data == 32'h2003_1003 && ins_addr == 32'h0,
        "R7 first held word intact", {ins_addr, ins_data}, {32'h0, 32'h2003_1003});
    @(negedge clk);
    #1;
    chk(ins_valid && ins_data == 32'h2013_1013 && ins_addr == 32'h4,
        "R7 second held word intact", {ins_addr, ins_data}, {32'h4, 32'h2013_1013});
    @(negedge clk);

    // sweep over length mixes and start addresses
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 6; s++) begin
        int starts [6] = '{0, 2, 4, 6, 10, 14};
        run_seq(m, starts[s], m * 8 + s);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule